// File: doc/BRIEF.md
# Rotational Bus Arbiter with Forced Release

This block decides which of four requester classes owns a shared system bus: a DMA engine, a memory-refresh agent, a group of bus-master cards and the host CPU. The classes take turns, but DMA is searched first after any tenure that was not its own, so a DMA request waits for at most one other tenure. The bus-master cards share one turn between them and rotate among themselves inside it. When nobody asks for the bus, the CPU is parked on it.

An owner with another request pending keeps its grant for a minimum tenure. After that the arbiter preempts it by dropping its grant and waits for the owner to drop its request. If the owner is still requesting when a timeout expires, the arbiter gives it a one-cycle reset pulse and hands the bus on. Only DMA and the bus-master cards have a reset output. Every handoff has one cycle with no grant at all.

Top module: `bus_rotary_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, only `cpu_gnt` is high and every reset output is low.
- R2: At most one grant output is high in any cycle.
- R3: A grant never rises in the cycle right after another grant was high: at least one cycle with no grant lies between two owners.
- R4: When the owner drops its request, its grant is low in the next cycle and the next winner is granted in the cycle after that.
- R5: After a tenure that was not DMA's, a pending DMA request wins the next grant. After a DMA tenure, DMA is searched last.
- R6: Refresh, the bus-master turn and the CPU are searched in the cyclic order refresh, bus master, CPU, starting just after whichever of the three was granted last. The order starts at refresh after reset.
- R7: Inside the bus-master turn, card i is searched first when card i-1 (mod N_MST) had the last card grant. The search starts at card 0 after reset.
- R8: If another request is pending, the owner keeps its grant for exactly MIN_TENURE cycles and then loses it.
- R9: A preempted owner that still requests after TIMEOUT cycles without a grant gets its reset output high for exactly one cycle, with no grant in that cycle. The next winner is granted one cycle later.
- R10: With no request, `cpu_gnt` is high. A request from the CPU alone keeps that grant high without a gap. Any other request takes it away in the next cycle.
- R11: A preempted owner that drops its request before the timeout causes no reset pulse. The next winner follows after one idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | 1 | DMA engine request |
| rfsh_req | input | 1 | Memory refresh request |
| mst_req | input | N_MST | One request per bus-master card |
| cpu_req | input | 1 | Host CPU request |
| dma_gnt | output | 1 | DMA engine grant |
| rfsh_gnt | output | 1 | Refresh grant |
| mst_gnt | output | N_MST | One grant per bus-master card |
| cpu_gnt | output | 1 | Host CPU grant |
| dma_rst | output | 1 | One-cycle forced reset to the DMA engine |
| mst_rst | output | N_MST | One-cycle forced reset per bus-master card |

## Verification
Grants and reset pulses come from registers, so every result appears one clock after the edge that samples the cause:
- A released grant is low one cycle after the request falls, and the next grant rises one cycle after that.
- A preemption lands MIN_TENURE cycles after the first grant cycle.
- The reset pulse follows TIMEOUT cycles later.

The bench drives its inputs and samples every output on the falling edge. Its checks are placed at those exact cycle offsets, not inside open-ended waits; the only exception is the first grant out of the parked state. The arbitration table checks each winner exactly two cycles after the previous owner released, which pins down both the idle gap and the search order.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    SLOT_DMA  = 2'd0,
    SLOT_RFSH = 2'd1,
    SLOT_MST  = 2'd2,
    SLOT_CPU  = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    PH_GRANT = 2'd0,
    PH_WAIT  = 2'd1,
    PH_GAP   = 2'd2
  } phase_e;

  // next class in the non-DMA rotation: refresh -> master -> cpu -> refresh
  function automatic slot_e next_nd(input slot_e s);
    case (s)
      SLOT_RFSH: next_nd = SLOT_MST;
      SLOT_MST:  next_nd = SLOT_CPU;
      default:   next_nd = SLOT_RFSH;
    endcase
  endfunction
endpackage

// File: rtl/busarb_card_rr.sv
module busarb_card_rr #(
  parameter int N_MST = 4,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req,
  input  logic [IW-1:0]    ptr,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic [IW-1:0]    ptr_adv
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N_MST - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % N_MST;
      if (req[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end

  always_comb begin
    if (int'(idx) == N_MST - 1) ptr_adv = '0;
    else                        ptr_adv = idx + 1'b1;
  end
endmodule

// File: rtl/busarb_slot_pick.sv
module busarb_slot_pick
  import busarb_pkg::*;
(
  input  logic [3:0] slot_req,
  input  slot_e      last_slot,
  input  slot_e      last_nd,
  output logic       win_any,
  output slot_e      win_slot
);
  slot_e r0, r1, r2;
  slot_e ord [4];

  always_comb begin
    r0 = next_nd(last_nd);
    r1 = next_nd(r0);
    r2 = next_nd(r1);
    if (last_slot == SLOT_DMA) begin
      ord[0] = r0; ord[1] = r1; ord[2] = r2; ord[3] = SLOT_DMA;
    end else begin
      ord[0] = SLOT_DMA; ord[1] = r0; ord[2] = r1; ord[3] = r2;
    end
  end

  always_comb begin
    win_any  = 1'b0;
    win_slot = SLOT_CPU;
    for (int k = 3; k >= 0; k--) begin
      if (slot_req[ord[k]]) begin
        win_any  = 1'b1;
        win_slot = ord[k];
      end
    end
  end
endmodule

// File: rtl/busarb_hold_timer.sv
module busarb_hold_timer #(
  parameter int MIN_TENURE = 4,
  parameter int TIMEOUT    = 64,
  localparam int TW = $clog2(MIN_TENURE) + 1,
  localparam int WW = $clog2(TIMEOUT) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ten_clr,
  input  logic ten_en,
  input  logic wait_clr,
  input  logic wait_en,
  output logic ten_done,
  output logic wait_done
);
  logic [TW-1:0] ten_q, ten_d;
  logic [WW-1:0] wait_q, wait_d;

  assign ten_done  = (int'(ten_q) >= MIN_TENURE - 1);
  assign wait_done = (int'(wait_q) == TIMEOUT - 1);

  always_comb begin
    ten_d = ten_q;
    if (ten_clr)                 ten_d = '0;
    else if (ten_en && !ten_done) ten_d = ten_q + 1'b1;
  end

  always_comb begin
    wait_d = wait_q;
    if (wait_clr)                  wait_d = '0;
    else if (wait_en && !wait_done) wait_d = wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ten_q  <= '0;
      wait_q <= '0;
    end else begin
      ten_q  <= ten_d;
      wait_q <= wait_d;
    end
  end

  // R9: once the timeout count is reached the controller leaves the wait phase
  wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && wait_done) |=> !wait_en);
endmodule

// File: rtl/bus_rotary_arbiter.sv
module bus_rotary_arbiter
  import busarb_pkg::*;
#(
  parameter int N_MST      = 4,
  parameter int MIN_TENURE = 4,
  parameter int TIMEOUT    = 64,
  localparam int IW = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_req,
  input  logic             rfsh_req,
  input  logic [N_MST-1:0] mst_req,
  input  logic             cpu_req,
  output logic             dma_gnt,
  output logic             rfsh_gnt,
  output logic [N_MST-1:0] mst_gnt,
  output logic             cpu_gnt,
  output logic             dma_rst,
  output logic [N_MST-1:0] mst_rst
);
  phase_e           phase_q, phase_d;
  slot_e            owner_q, owner_d;
  slot_e            last_q, last_d;
  slot_e            lastnd_q, lastnd_d;
  logic [IW-1:0]    oidx_q, oidx_d;
  logic [IW-1:0]    mptr_q, mptr_d;
  logic             parked_q, parked_d;
  logic             drst_q, drst_d;
  logic [N_MST-1:0] mrst_q, mrst_d;

  logic [3:0]       slot_req;
  logic             win_any;
  slot_e            win_slot;
  logic             card_hit;
  logic [IW-1:0]    card_idx, card_ptr_adv;
  logic             owner_req, others_pend, non_cpu_any, unpark;
  logic             ten_done, wait_done;
  logic [N_MST-1:0] own_mask;

  assign slot_req    = {cpu_req, |mst_req, rfsh_req, dma_req};
  assign own_mask    = N_MST'(1) << oidx_q;
  assign non_cpu_any = dma_req | rfsh_req | (|mst_req);

  always_comb begin
    case (owner_q)
      SLOT_DMA:  owner_req = dma_req;
      SLOT_RFSH: owner_req = rfsh_req;
      SLOT_MST:  owner_req = |(mst_req & own_mask);
      default:   owner_req = cpu_req;
    endcase
  end

  always_comb begin
    others_pend = |(slot_req & ~(4'b0001 << owner_q));
    if (owner_q == SLOT_MST && |(mst_req & ~own_mask)) others_pend = 1'b1;
  end

  busarb_slot_pick u_pick (
    .slot_req (slot_req),
    .last_slot(last_q),
    .last_nd  (lastnd_q),
    .win_any  (win_any),
    .win_slot (win_slot)
  );

  busarb_card_rr #(.N_MST(N_MST)) u_card (
    .req    (mst_req),
    .ptr    (mptr_q),
    .hit    (card_hit),
    .idx    (card_idx),
    .ptr_adv(card_ptr_adv)
  );

  assign unpark = (phase_q == PH_GRANT) && parked_q && !non_cpu_any && cpu_req;

  busarb_hold_timer #(.MIN_TENURE(MIN_TENURE), .TIMEOUT(TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ten_clr  ((phase_q != PH_GRANT) || unpark),
    .ten_en   (phase_q == PH_GRANT),
    .wait_clr (phase_q != PH_WAIT),
    .wait_en  (phase_q == PH_WAIT),
    .ten_done (ten_done),
    .wait_done(wait_done)
  );

  always_comb begin
    phase_d  = phase_q;
    owner_d  = owner_q;
    last_d   = last_q;
    lastnd_d = lastnd_q;
    oidx_d   = oidx_q;
    mptr_d   = mptr_q;
    parked_d = parked_q;
    drst_d   = 1'b0;
    mrst_d   = '0;
    case (phase_q)
      PH_GRANT: begin
        if (parked_q) begin
          if (non_cpu_any) begin
            phase_d  = PH_GAP;
            parked_d = 1'b0;
          end else if (cpu_req) begin
            parked_d = 1'b0;
            last_d   = SLOT_CPU;
            lastnd_d = SLOT_CPU;
          end
        end else if (!owner_req) begin
          phase_d = PH_GAP;
        end else if (others_pend && ten_done) begin
          phase_d = PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (!owner_req) begin
          phase_d = PH_GAP;
        end else if (wait_done) begin
          phase_d = PH_GAP;
          drst_d  = (owner_q == SLOT_DMA);
          mrst_d  = (owner_q == SLOT_MST) ? own_mask : '0;
        end
      end
      default: begin
        phase_d = PH_GRANT;
        if (win_any) begin
          owner_d  = win_slot;
          last_d   = win_slot;
          parked_d = 1'b0;
          if (win_slot != SLOT_DMA) lastnd_d = win_slot;
          if (win_slot == SLOT_MST && card_hit) begin
            oidx_d = card_idx;
            mptr_d = card_ptr_adv;
          end
        end else begin
          owner_d  = SLOT_CPU;
          parked_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_GRANT;
      owner_q  <= SLOT_CPU;
      last_q   <= SLOT_CPU;
      lastnd_q <= SLOT_CPU;
      oidx_q   <= '0;
      mptr_q   <= '0;
      parked_q <= 1'b1;
      drst_q   <= 1'b0;
      mrst_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      owner_q  <= owner_d;
      last_q   <= last_d;
      lastnd_q <= lastnd_d;
      oidx_q   <= oidx_d;
      mptr_q   <= mptr_d;
      parked_q <= parked_d;
      drst_q   <= drst_d;
      mrst_q   <= mrst_d;
    end
  end

  logic live;
  assign live     = (phase_q == PH_GRANT);
  assign dma_gnt  = live && (owner_q == SLOT_DMA);
  assign rfsh_gnt = live && (owner_q == SLOT_RFSH);
  assign cpu_gnt  = live && (owner_q == SLOT_CPU);
  assign mst_gnt  = (live && owner_q == SLOT_MST) ? own_mask : '0;
  assign dma_rst  = drst_q;
  assign mst_rst  = mrst_q;

  logic [N_MST+2:0] gvec;
  assign gvec = {cpu_gnt, mst_gnt, rfsh_gnt, dma_gnt};

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gvec));

  // R3
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gvec != '0 && gvec != $past(gvec)) |-> ($past(gvec) == '0));

  // R4
  dma_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_req) |=> !dma_gnt);

  // R4
  card_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mst_gnt & ~mst_req) != '0) |=> (mst_gnt == '0));

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rst || mst_rst != '0) |=> (!dma_rst && mst_rst == '0));

  // R9
  rst_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rst || mst_rst != '0) |-> (gvec == '0 && $countones({dma_rst, mst_rst}) == 1));
endmodule

// File: tb/sim_bus_rotary_arbiter.sv
module sim_bus_rotary_arbiter;
  localparam int NM = 4;
  localparam int MT = 4;
  localparam int TO = 64;

  // each entry: {requests added (7 bits), expected grant (7 bits)}
  // bit layout: [6] cpu, [5:2] card3..card0, [1] refresh, [0] dma
  localparam logic [13:0] VEC [14] = '{
    {7'h47, 7'h01}, {7'h00, 7'h02}, {7'h01, 7'h01}, {7'h10, 7'h04},
    {7'h00, 7'h40}, {7'h0A, 7'h02}, {7'h00, 7'h08}, {7'h04, 7'h10},
    {7'h20, 7'h20}, {7'h01, 7'h01}, {7'h00, 7'h04}, {7'h41, 7'h01},
    {7'h01, 7'h40}, {7'h00, 7'h01}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [6:0]    pend;
  logic          dma_req, rfsh_req, cpu_req;
  logic [NM-1:0] mst_req;
  logic          dma_gnt, rfsh_gnt, cpu_gnt, dma_rst;
  logic [NM-1:0] mst_gnt, mst_rst;
  logic [6:0]    gvec;
  logic [4:0]    rvec;

  assign {cpu_req, mst_req, rfsh_req, dma_req} = pend;
  assign gvec = {cpu_gnt, mst_gnt, rfsh_gnt, dma_gnt};
  assign rvec = {mst_rst, dma_rst};

  bus_rotary_arbiter #(.N_MST(NM), .MIN_TENURE(MT), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dma_req(dma_req), .rfsh_req(rfsh_req), .mst_req(mst_req), .cpu_req(cpu_req),
    .dma_gnt(dma_gnt), .rfsh_gnt(rfsh_gnt), .mst_gnt(mst_gnt), .cpu_gnt(cpu_gnt),
    .dma_rst(dma_rst), .mst_rst(mst_rst)
  );

  int errs = 0;
  int chks = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_for(input logic [6:0] mask);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if ((gvec & mask) != 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    chks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic [4:0] rst_seen;
    pend  = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", {1'b0, gvec}, 8'h40);
    chk("R1 resets in reset", {3'b0, rvec}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", {1'b0, gvec}, 8'h40);

    // arbitration order table: R5 R6 R7, with R4 and R3 on every handoff
    for (int r = 0; r < 14; r++) begin
      pend = pend | VEC[r][13:7];
      if (r == 0) wait_for(pend);
      else        @(negedge clk);
      chk($sformatf("R5 R6 R7 row %0d", r), {1'b0, gvec}, {1'b0, VEC[r][6:0]});
      pend = pend & ~VEC[r][6:0];
      @(negedge clk);
      chk($sformatf("R4 R3 gap row %0d", r), {1'b0, gvec}, 8'h00);
    end
    @(negedge clk);
    chk("R10 parked cpu", {1'b0, gvec}, 8'h40);

    // R10 cpu request while parked keeps the grant without a gap
    pend = 7'h40;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 cpu keeps grant", {1'b0, gvec}, 8'h40);
    end
    pend = '0;
    @(negedge clk);
    chk("R4 cpu release gap", {1'b0, gvec}, 8'h00);
    @(negedge clk);
    chk("R10 cpu parked again", {1'b0, gvec}, 8'h40);

    // R8 / R9: card 1 ignores preemption
    pend = 7'h08;
    wait_for(7'h08);
    chk("R10 card1 granted", {1'b0, gvec}, 8'h08);
    pend = pend | 7'h02;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R8 tenure held", {1'b0, gvec}, 8'h08);
    end
    @(negedge clk);
    chk("R8 preempted", {1'b0, gvec}, 8'h00);
    for (int k = 5; k <= 67; k++) @(negedge clk);
    chk("R9 no reset before timeout", {3'b0, rvec}, 8'h00);
    @(negedge clk);
    chk("R9 reset pulse card1", {3'b0, rvec}, 8'h04);
    chk("R9 no grant during reset", {1'b0, gvec}, 8'h00);
    @(negedge clk);
    chk("R9 next owner refresh", {1'b0, gvec}, 8'h02);
    chk("R9 reset is one cycle", {3'b0, rvec}, 8'h00);
    pend = 7'h02;
    @(negedge clk);
    pend = '0;
    @(negedge clk);
    chk("R4 refresh release", {1'b0, gvec}, 8'h00);
    @(negedge clk);

    // R11: card 2 releases late but inside the timeout
    pend = 7'h10;
    wait_for(7'h10);
    pend = pend | 7'h01;
    rst_seen = '0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      rst_seen = rst_seen | rvec;
      if (k == 4) chk("R8 card2 preempted", {1'b0, gvec}, 8'h00);
    end
    pend = 7'h01;
    @(negedge clk);
    rst_seen = rst_seen | rvec;
    chk("R11 gap after release", {1'b0, gvec}, 8'h00);
    @(negedge clk);
    rst_seen = rst_seen | rvec;
    chk("R11 dma follows", {1'b0, gvec}, 8'h01);
    chk("R11 no reset pulse", {3'b0, rst_seen}, 8'h00);
    pend = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle parks cpu", {1'b0, gvec}, 8'h40);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule